// File: doc/BRIEF.md
# Class-Partitioned Register Rename Table

This block holds the speculative architectural-to-physical register mapping for an out-of-order core. Architectural registers reach it through one flat index. The block splits that index into four classes: integer, floating point, condition code and miscellaneous. It also derives an index relative to the start of the class. The integer, floating-point and condition-code classes each have their own map table and their own FIFO of free physical registers. Physical indices are numbered separately within each class.

Three operations can run in the same cycle:

- **Rename** returns the mapping the register had before and a freshly allocated physical register. It commits the new mapping on the next rising edge.
- **Lookup** reads the current mapping combinationally.
- **Set-entry** overwrites one mapping and is used by commit and squash recovery.

A separate return port gives released physical registers back to their class's free list. The integer and floating-point classes each have one hard-wired zero register that is never renamed. Miscellaneous registers keep a fixed identity mapping.

Top module: `regclass_rename`

## Requirements
- R1: After reset, architectural register k of each class maps to physical k of that class. The free list of a class with A architectural and P physical registers holds A..P-1, in ascending order from the head.
- R2: Rename of a renamable register does the following:
  - `ren_prev` shows the current mapping and `ren_new` shows the head of the class free list.
  - On the rising edge, the head is popped and written into the map entry.
  - A later rename of the same class gets the next free-list entry.
- R3: Rename of the integer zero register (relative index ZI) or the float zero register (relative index ZF) returns the zero index as both `ren_new` and `ren_prev`. It consumes no free entry, keeps `ren_ready` high and changes nothing. A set-entry on a zero register with any value other than its current mapping raises `set_err` and changes nothing.
- R4: The condition-code class has no zero register. Every condition-code register, relative index 0 included, renames from its free list.
- R5: Class decode of the flat index:
  - [0, NI) is integer.
  - [NI, NI+NF) is float.
  - The next NC indices are condition code.
  - The next NM indices are miscellaneous.
  - The relative index is the flat index minus the class base.
- R6: A miscellaneous register is never renamed. Rename and lookup return its relative index as the mapping, with `ren_new` equal to `ren_prev`. A set-entry with a value other than the relative index raises `set_err`; one with the same value raises no error.
- R7: A flat index at or above NI+NF+NC+NM raises `ren_err`, `lk_err` or `set_err` on the port that carries it, and no state changes.
- R8: Set-entry with no error writes `set_phys` into the map entry on the rising edge. When a rename and a set-entry target the same entry in the same cycle, the set-entry value is the one kept.
- R9: A rename of a renamable register whose class free list is empty drives `ren_ready` low. The map and the free list then stay unchanged.
- R10: Lookup is combinational. In a cycle where a rename or set-entry updates the looked-up entry, `lk_phys` still shows the value from before the update.
- R11: A release with `rel_class` 0 (integer), 1 (float) or 2 (condition code) pushes `rel_phys` onto the tail of that class's free list. It is handed out after every entry already queued. `rel_class` 3 is ignored.
- R12: Under mixed rename and release traffic, no physical register is mapped by two architectural registers of the same class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_idx | input | AW | Flat index to look up |
| lk_phys | output | PW | Current mapping of `lk_idx` |
| lk_err | output | 1 | `lk_idx` decodes to no class |
| ren_valid | input | 1 | Rename request |
| ren_idx | input | AW | Flat index to rename |
| ren_ready | output | 1 | Low when the target class has no free register |
| ren_err | output | 1 | `ren_idx` decodes to no class |
| ren_new | output | PW | Newly assigned physical register |
| ren_prev | output | PW | Mapping before the rename |
| set_valid | input | 1 | Set-entry request |
| set_idx | input | AW | Flat index to overwrite |
| set_phys | input | PW | Value to write |
| set_err | output | 1 | Set-entry refused (bad index, or change of a fixed mapping) |
| rel_valid | input | 1 | Release a physical register |
| rel_class | input | 2 | Class of the released register (0 int, 1 float, 2 cc, 3 misc) |
| rel_phys | input | PW | Released physical index |

## Verification
The bench first sweeps lookup over every value of a 5-bit flat index. This separates the four class ranges and the invalid tail of the index space, and shows the reset identity mapping.

Repeated rename sweeps over all renamable indices follow, each rename paired with a release of the old mapping. These show that allocations come out in FIFO order and that released registers come back only after those already queued. They also show that the zero registers and the condition-code register at relative index 0 behave differently.

A final block of directed patterns covers the remaining corners:

- A set-entry restores a mapping after a rename, and a set-entry colliding with a rename in the same cycle is the value kept.
- A lookup in the same cycle as a rename shows the value from before the update.
- Fixed mappings are rewritten with a wrong value and with the same value.
- A condition-code free list is drained until rename stalls, then refilled by one release.

// File: rtl/regclass_rename.sv
module regclass_rename #(
  parameter int NI = 8,
  parameter int NF = 8,
  parameter int NC = 4,
  parameter int NM = 4,
  parameter int PI = 16,
  parameter int PF = 16,
  parameter int PC = 8,
  parameter int ZI = 0,
  parameter int ZF = 0,
  parameter int AW = 5,
  localparam int NR = NI + NF + NC,
  localparam int NT = NR + NM,
  localparam int PMAX = (PI > PF) ? ((PI > PC) ? PI : PC) : ((PF > PC) ? PF : PC),
  localparam int PW = $clog2(PMAX),
  localparam int CW = $clog2(PMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_idx,
  output logic [PW-1:0] lk_phys,
  output logic          lk_err,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_idx,
  output logic          ren_ready,
  output logic          ren_err,
  output logic [PW-1:0] ren_new,
  output logic [PW-1:0] ren_prev,
  input  logic          set_valid,
  input  logic [AW-1:0] set_idx,
  input  logic [PW-1:0] set_phys,
  output logic          set_err,
  input  logic          rel_valid,
  input  logic [1:0]    rel_class,
  input  logic [PW-1:0] rel_phys
);

  localparam logic [1:0] MISC = 2'd3;

  logic [PW-1:0]        map_q [NR];
  logic [2:0][PW-1:0]   fl_head;
  logic [2:0][CW-1:0]   fl_cnt;

  function automatic logic [AW+2:0] dec(input logic [AW-1:0] i);
    int v;
    v = int'(i);
    if (v < NI)           return {1'b0, 2'd0, AW'(v)};
    else if (v < NI + NF) return {1'b0, 2'd1, AW'(v - NI)};
    else if (v < NR)      return {1'b0, 2'd2, AW'(v - NI - NF)};
    else if (v < NT)      return {1'b0, MISC, AW'(v - NR)};
    else                  return {1'b1, MISC, AW'(0)};
  endfunction

  function automatic logic is_zero(input logic [AW-1:0] i);
    return (int'(i) == ZI) || (int'(i) == NI + ZF);
  endfunction

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (int'(p) == PMAX - 1) ? '0 : p + 1'b1;
  endfunction

  logic          rb, sb, lb;
  logic [1:0]    rc, sc, lc;
  logic [AW-1:0] rr, sr, lr;

  assign {rb, rc, rr} = dec(ren_idx);
  assign {sb, sc, sr} = dec(set_idx);
  assign {lb, lc, lr} = dec(lk_idx);

  logic ren_ok, commit, set_do;

  assign ren_ok    = !rb && (rc != MISC) && !is_zero(ren_idx);
  assign ren_err   = rb;
  assign ren_prev  = rb ? '0 : (rc == MISC) ? PW'(rr) : map_q[ren_idx];
  assign ren_new   = ren_ok ? fl_head[rc] : ren_prev;
  assign ren_ready = !(ren_ok && (fl_cnt[rc] == '0));
  assign commit    = ren_valid && ren_ok && ren_ready;

  assign lk_err  = lb;
  assign lk_phys = lb ? '0 : (lc == MISC) ? PW'(lr) : map_q[lk_idx];

  assign set_err = sb
                 || ((sc == MISC) && (set_phys != PW'(sr)))
                 || ((sc != MISC) && is_zero(set_idx) && (set_phys != map_q[set_idx]));
  assign set_do  = set_valid && !set_err && (sc != MISC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++)
        map_q[i] <= PW'((i < NI) ? i : (i < NI + NF) ? (i - NI) : (i - NI - NF));
    end else begin
      if (commit) map_q[ren_idx] <= fl_head[rc];
      if (set_do) map_q[set_idx] <= set_phys;
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_fl
    localparam int NP    = (c == 0) ? PI : (c == 1) ? PF : PC;
    localparam int NA    = (c == 0) ? NI : (c == 1) ? NF : NC;
    localparam int NFREE = NP - NA;

    logic [PW-1:0] slot_q [PMAX];
    logic [PW-1:0] hd_q, tl_q;
    logic [CW-1:0] cnt_q;
    logic          pop, push;

    assign pop        = commit && (rc == 2'(c));
    assign push       = rel_valid && (rel_class == 2'(c)) && (int'(cnt_q) < PMAX);
    assign fl_head[c] = slot_q[hd_q];
    assign fl_cnt[c]  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < PMAX; k++)
          slot_q[k] <= (k < NFREE) ? PW'(NA + k) : '0;
        hd_q  <= '0;
        tl_q  <= PW'(NFREE % PMAX);
        cnt_q <= CW'(NFREE);
      end else begin
        if (pop) hd_q <= nxt(hd_q);
        if (push) begin
          slot_q[tl_q] <= rel_phys;
          tl_q         <= nxt(tl_q);
        end
        if (pop != push) cnt_q <= pop ? cnt_q - 1'b1 : cnt_q + 1'b1;
      end
    end
  end

endmodule

module regclass_rename_chk #(
  parameter int NI = 8,
  parameter int NF = 8,
  parameter int NC = 4,
  parameter int NM = 4,
  parameter int ZI = 0,
  parameter int ZF = 0,
  parameter int AW = 5,
  parameter int PW = 4,
  parameter int CW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ren_valid,
  input logic [AW-1:0]     ren_idx,
  input logic              ren_ready,
  input logic              ren_err,
  input logic [PW-1:0]     ren_new,
  input logic [PW-1:0]     ren_prev,
  input logic              set_valid,
  input logic [AW-1:0]     set_idx,
  input logic [PW-1:0]     set_phys,
  input logic              set_err,
  input logic              rel_valid,
  input logic [2:0][CW-1:0] cnt
);
  localparam int NR = NI + NF + NC;
  localparam int NT = NR + NM;

  a_r3_zero_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && (int'(ren_idx) == ZI || int'(ren_idx) == NI + ZF)
      |-> (ren_new == ren_prev) && ren_ready && !ren_err);

  a_r6_misc_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && int'(ren_idx) >= NR && int'(ren_idx) < NT
      |-> (ren_new == ren_prev) && (int'(ren_new) == int'(ren_idx) - NR));

  a_r6_misc_set_guard: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid && int'(set_idx) >= NR && int'(set_idx) < NT
      && int'(set_phys) != int'(set_idx) - NR |-> set_err);

  a_r7_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ren_idx) >= NT |-> ren_err);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && !ren_ready && !rel_valid |=> $stable(cnt));
endmodule

bind regclass_rename regclass_rename_chk #(
  .NI(NI), .NF(NF), .NC(NC), .NM(NM), .ZI(ZI), .ZF(ZF), .AW(AW), .PW(PW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ren_valid(ren_valid), .ren_idx(ren_idx), .ren_ready(ren_ready), .ren_err(ren_err),
  .ren_new(ren_new), .ren_prev(ren_prev),
  .set_valid(set_valid), .set_idx(set_idx), .set_phys(set_phys), .set_err(set_err),
  .rel_valid(rel_valid), .cnt(fl_cnt)
);

// File: tb/sim_regclass_rename.sv
`timescale 1ns/1ps
module sim_regclass_rename;
  localparam int NI = 8, NF = 8, NC = 4, NM = 4, AW = 5, PW = 4;
  localparam int NR = NI + NF + NC, NT = NR + NM;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] lk_idx = '0, ren_idx = '0, set_idx = '0;
  logic [PW-1:0] lk_phys, ren_new, ren_prev;
  logic [PW-1:0] set_phys = '0, rel_phys = '0;
  logic lk_err, ren_ready, ren_err, set_err;
  logic ren_valid = 0, set_valid = 0, rel_valid = 0;
  logic [1:0] rel_class = '0;

  regclass_rename u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_phys(lk_phys), .lk_err(lk_err),
    .ren_valid(ren_valid), .ren_idx(ren_idx), .ren_ready(ren_ready), .ren_err(ren_err),
    .ren_new(ren_new), .ren_prev(ren_prev),
    .set_valid(set_valid), .set_idx(set_idx), .set_phys(set_phys), .set_err(set_err),
    .rel_valid(rel_valid), .rel_class(rel_class), .rel_phys(rel_phys)
  );

  int n_cmp = 0, n_bad = 0;
  int mmap[NR];
  int q0[$], q1[$], q2[$];
  int last_new, last_prev, last_dut_new;

  function automatic int cls_of(int i);
    return (i < NI) ? 0 : (i < NI + NF) ? 1 : (i < NR) ? 2 : (i < NT) ? 3 : 4;
  endfunction
  function automatic int rel_of(int i);
    return (i < NI) ? i : (i < NI + NF) ? i - NI : (i < NR) ? i - NI - NF : i - NR;
  endfunction
  function automatic bit is_zero(int i);
    return (i == 0) || (i == NI);
  endfunction
  function automatic int qsize(int c);
    return (c == 0) ? q0.size() : (c == 1) ? q1.size() : q2.size();
  endfunction
  function automatic int qfront(int c);
    return (c == 0) ? q0[0] : (c == 1) ? q1[0] : q2[0];
  endfunction
  function automatic void qpop(int c);
    if (c == 0) void'(q0.pop_front());
    else if (c == 1) void'(q1.pop_front());
    else void'(q2.pop_front());
  endfunction
  function automatic void qpush(int c, int v);
    if (c == 0) q0.push_back(v);
    else if (c == 1) q1.push_back(v);
    else q2.push_back(v);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ren(int i);
    int c;
    bit upd;
    c = cls_of(i);
    upd = 0;
    last_new = -1; last_prev = -1;
    @(negedge clk);
    ren_valid = 1; ren_idx = AW'(i);
    #1;
    last_dut_new = int'(ren_new);
    if (c == 4) chk("R7 rename error", ren_err, 1);
    else if (c == 3) begin
      chk("R6 misc new", ren_new, rel_of(i));
      chk("R6 misc prev", ren_prev, rel_of(i));
    end else if (is_zero(i)) begin
      chk("R3 zero new", ren_new, rel_of(i));
      chk("R3 zero prev", ren_prev, rel_of(i));
      chk("R3 zero ready", ren_ready, 1);
    end else if (qsize(c) == 0) begin
      chk("R9 stall ready", ren_ready, 0);
    end else begin
      if (c == 2) chk("R4 cc renames from list", ren_new, qfront(c));
      else chk("R2 new from list head", ren_new, qfront(c));
      chk("R2 prev mapping", ren_prev, mmap[i]);
      last_new = qfront(c); last_prev = mmap[i];
      upd = 1;
    end
    @(posedge clk); #1;
    ren_valid = 0;
    if (upd) begin qpop(c); mmap[i] = last_new; end
  endtask

  task automatic rel(int c, int p);
    @(negedge clk);
    rel_valid = 1; rel_class = 2'(c); rel_phys = PW'(p);
    @(posedge clk); #1;
    rel_valid = 0;
    if (c < 3) qpush(c, p);
  endtask

  task automatic lk(int i, string tag);
    int c;
    c = cls_of(i);
    @(negedge clk);
    lk_idx = AW'(i);
    #1;
    if (c == 4) chk(tag, lk_err, 1);
    else chk(tag, lk_phys, (c == 3) ? rel_of(i) : mmap[i]);
  endtask

  task automatic st(int i, int p, int experr, string tag);
    @(negedge clk);
    set_valid = 1; set_idx = AW'(i); set_phys = PW'(p);
    #1;
    chk(tag, set_err, experr);
    @(posedge clk); #1;
    set_valid = 0;
    if (experr == 0 && cls_of(i) < 3) mmap[i] = p;
  endtask

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int saved[8];
    int ns, n;
    for (int i = 0; i < NR; i++) mmap[i] = rel_of(i);
    for (int k = NI; k < 16; k++) q0.push_back(k);
    for (int k = NF; k < 16; k++) q1.push_back(k);
    for (int k = NC; k < 8; k++) q2.push_back(k);
    #12 rst_n = 1;

    // R1 reset identity, R5 class ranges, R7 invalid tail
    for (int i = 0; i < 32; i++) begin
      if (i >= NT) lk(i, "R7 lookup error");
      else if (i >= NR) lk(i, "R6 misc lookup");
      else lk(i, "R1 R5 reset mapping");
    end

    // R2 R3 R4 R11 sweeps: rename, then release old mapping
    for (int r = 0; r < 5; r++)
      for (int i = 0; i < NR; i++) begin
        ren(i);
        if (last_new >= 0) rel(cls_of(i), last_prev);
      end

    // R12 uniqueness within each class
    for (int c = 0; c < 3; c++) begin
      int vals[NR];
      int dups, lo, hi;
      lo = (c == 0) ? 0 : (c == 1) ? NI : NI + NF;
      hi = (c == 0) ? NI : (c == 1) ? NI + NF : NR;
      dups = 0;
      for (int i = lo; i < hi; i++) begin
        lk(i, "R12 mapping matches model");
        vals[i] = int'(lk_phys);
        for (int j = lo; j < i; j++) if (vals[j] == vals[i]) dups++;
      end
      chk("R12 duplicate mappings", dups, 0);
    end

    // R6 misc fixed mappings
    ren(21);
    st(21, 5, 1, "R6 misc set wrong value");
    lk(21, "R6 misc lookup unchanged");
    st(21, 1, 0, "R6 misc set same value");

    // R7 invalid index leaves state alone
    ren(28);
    st(28, 0, 1, "R7 set error");
    lk(5, "R7 map untouched");

    // R3 zero register set-entry
    st(0, 3, 1, "R3 zero set wrong value");
    lk(0, "R3 zero unchanged");
    st(NI, 0, 0, "R3 float zero set same value");

    // R8 restore after rename
    ren(3);
    n = last_new;
    st(3, last_prev, 0, "R8 set restore");
    lk(3, "R8 lookup restored");
    rel(0, n);

    // R8 + R10 same-cycle rename, set and lookup on one entry
    @(negedge clk);
    ren_valid = 1; ren_idx = AW'(4);
    set_valid = 1; set_idx = AW'(4); set_phys = PW'(mmap[4]);
    lk_idx = AW'(4);
    #1;
    n = qfront(0);
    chk("R10 lookup pre-update", lk_phys, mmap[4]);
    chk("R2 new from list head", ren_new, n);
    @(posedge clk); #1;
    ren_valid = 0; set_valid = 0;
    qpop(0);
    lk(4, "R8 set wins over rename");
    rel(0, n);

    // R9 drain condition-code list, stall, then R11 refill
    ns = 0;
    while (qsize(2) > 0 && ns < 8) begin
      ren(NI + NF + (ns % NC));
      saved[ns] = last_prev;
      ns++;
    end
    ren(NI + NF);
    chk("R9 stall no error", ren_err, 0);
    lk(NI + NF, "R9 map unchanged after stall");
    rel(3, 7);
    ren(NI + NF + 1);
    chk("R11 misc release ignored", ren_ready, 0);
    rel(2, saved[0]);
    ren(NI + NF + 1);
    chk("R11 released register reused", last_dut_new, saved[0]);

    summary();
  end
endmodule